// File: doc/BRIEF.md
# Multichannel Stepped-Frequency PWM Generator

This block drives a bank of independent pulse-width modulated outputs from one shared time base. Each channel has a frequency code, a duty code, an invert flag and an enable flag. The frequency code combines a 2-bit scale with a 6-bit multiplier. The output frequency is (multiplier+1) times a base of 0.5 Hz, 2 Hz, 8 Hz or 32 Hz, chosen by the scale. This covers 0.5 Hz to 2048 Hz. The duty code sets the high time in 1/256 steps of the period. The lowest code still gives one step high, so no code yields 0 %.

A clock divider produces a fine tick at 4096 × 128 Hz. Each channel adds its increment (multiplier+1) << (2·scale) to a 20-bit accumulator on every tick. The top 8 bits of the accumulator form a 256-position phase. The channel output is high while the phase is at or below the duty code, and low for the rest of the period. The polarity flag, the enable flag and a global normal-mode input are applied after that comparison, and the result is registered.

Configuration changes are used at once. Nothing restarts the accumulators, so one period may mix the old and new settings.

Top module: `stepped_pwm_bank`

## Requirements
- R1: Frequency byte: bits 7:6 are the scale S and bits 5:0 are the multiplier M. The phase advances by (M+1)<<(2·S) / 4096 positions per fine tick. The period is therefore 2^20/((M+1)<<(2·S)) ticks, and encodings with equal increments behave identically.
- R2: With duty code D and normal polarity, an enabled channel is high for phases 0 through D inclusive. Its high time is (D+1)/256 of the period.
- R3: Duty code 255 gives a constant high output on an enabled, non-inverted channel.
- R4: When a channel's invert bit is 1, its enabled output is the bitwise complement of the non-inverted waveform.
- R5: A channel whose enable bit is 0 outputs low, whatever its invert bit and duty code.
- R6: While normal_mode is 0, every output is low.
- R7: New frequency, duty, polarity or enable values take effect without resetting the phase accumulators.
- R8: During synchronous reset all outputs are low, and all accumulators and the divider start at zero.
- R9: Each output is registered. It reflects the inputs and the accumulator state of the preceding clock cycle.
- R10: The fine tick occurs once every TICK_DIV clock cycles. It is registered, so the first tick comes TICK_DIV cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| normal_mode | input | 1 | Global output gate, 1 = outputs active |
| freq_cfg | input | NCH*8 | Per-channel frequency byte (scale, multiplier) |
| duty_cfg | input | NCH*8 | Per-channel duty code |
| pol_inv | input | NCH | Per-channel invert flag |
| chan_en | input | NCH | Per-channel enable |
| pwm_out | output | NCH | Channel outputs |

## Verification
Every output is due exactly one clock after the inputs and accumulator state that produce it. An accumulator moves one clock after a fine tick, and that tick rises TICK_DIV clocks after its divider count begins. The bench holds a reference model that steps at each rising edge: it first computes the next outputs from the state before the edge, then advances its own divider and accumulators. The bench compares the outputs at the falling edge. Inputs change only at falling edges. Gating, inversion and duty-window checks therefore land one cycle after a change. Full-period measurements count high cycles and rising edges over windows that span whole periods, so their alignment does not affect the result.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int STEP_W  = 2;
  localparam int CODE_W  = 6;
  localparam int PHASE_W = 8;
  localparam int CFG_W   = STEP_W + CODE_W;
  localparam int INC_W   = CODE_W + 1 + 2 * ((1 << STEP_W) - 1);

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [CODE_W-1:0] code;
  } freq_t;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int TICK_DIV = 96
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int FRAC_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  freq_t              freq,
  input  logic [PHASE_W-1:0] duty,
  input  logic               invert,
  input  logic               enable,
  input  logic               normal,
  output logic               wave
);
  localparam int ACC_W = PHASE_W + FRAC_W;

  logic [INC_W-1:0]   mult;
  logic [INC_W-1:0]   inc;
  logic [ACC_W-1:0]   acc;
  logic [PHASE_W-1:0] phase;
  logic               in_window;

  // increment = (multiplier + 1) scaled by 4^step
  always_comb begin
    mult      = INC_W'(freq.code) + 1'b1;
    inc       = mult << {freq.step, 1'b0};
    phase     = acc[ACC_W-1 -: PHASE_W];
    in_window = (phase <= duty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      wave <= 1'b0;
    end else begin
      if (tick) acc <= acc + ACC_W'(inc);
      wave <= normal & enable & (in_window ^ invert);
    end
  end
endmodule

// File: rtl/stepped_pwm_bank.sv
module stepped_pwm_bank
  import pwm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int TICK_DIV = 96,
  parameter int FRAC_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               normal_mode,
  input  logic [NCH*8-1:0]   freq_cfg,
  input  logic [NCH*8-1:0]   duty_cfg,
  input  logic [NCH-1:0]     pol_inv,
  input  logic [NCH-1:0]     chan_en,
  output logic [NCH-1:0]     pwm_out
);
  logic fine_tick;

  pwm_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk  (clk),
    .rst  (rst),
    .tick (fine_tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    freq_t f_i;
    assign f_i = freq_t'(freq_cfg[i*CFG_W +: CFG_W]);

    pwm_channel #(.FRAC_W(FRAC_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .tick   (fine_tick),
      .freq   (f_i),
      .duty   (duty_cfg[i*PHASE_W +: PHASE_W]),
      .invert (pol_inv[i]),
      .enable (chan_en[i]),
      .normal (normal_mode),
      .wave   (pwm_out[i])
    );
  end
endmodule

// File: rtl/stepped_pwm_bank_chk.sv
module stepped_pwm_bank_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             normal_mode,
  input logic [NCH*8-1:0] duty_cfg,
  input logic [NCH-1:0]   pol_inv,
  input logic [NCH-1:0]   chan_en,
  input logic [NCH-1:0]   pwm_out
);
  a_r8_reset_low: assert property (@(posedge clk) rst |=> (pwm_out == '0));

  a_r6_mode_gate: assert property (@(posedge clk) disable iff (rst)
    !normal_mode |=> (pwm_out == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
      !chan_en[i] |=> !pwm_out[i]);

    a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
      (normal_mode && chan_en[i] && !pol_inv[i] && duty_cfg[i*8 +: 8] == 8'hFF)
      |=> pwm_out[i]);

    a_r4_full_inverted: assert property (@(posedge clk) disable iff (rst)
      (normal_mode && chan_en[i] && pol_inv[i] && duty_cfg[i*8 +: 8] == 8'hFF)
      |=> !pwm_out[i]);
  end
endmodule

bind stepped_pwm_bank stepped_pwm_bank_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .normal_mode (normal_mode),
  .duty_cfg    (duty_cfg),
  .pol_inv     (pol_inv),
  .chan_en     (chan_en),
  .pwm_out     (pwm_out)
);

// File: tb/test_stepped_pwm_bank.sv
`timescale 1ns/1ps
module test_stepped_pwm_bank;
  localparam int NCH = 4;
  localparam int DIV = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             normal_mode = 1'b0;
  logic [NCH*8-1:0] freq_cfg = '0;
  logic [NCH*8-1:0] duty_cfg = '0;
  logic [NCH-1:0]   pol_inv = '0;
  logic [NCH-1:0]   chan_en = '0;
  logic [NCH-1:0]   pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  stepped_pwm_bank #(.NCH(NCH), .TICK_DIV(DIV)) i_stepped_pwm_bank (
    .clk(clk), .rst(rst), .normal_mode(normal_mode), .freq_cfg(freq_cfg),
    .duty_cfg(duty_cfg), .pol_inv(pol_inv), .chan_en(chan_en), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase position in units of 1/4096
  int          m_div;
  bit          m_tick;
  longint      m_pos [NCH];
  logic [NCH-1:0] m_exp;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_tick = 0; m_exp = '0;
      for (int c = 0; c < NCH; c++) m_pos[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int ph, d, s, m;
        bit hi;
        ph = int'((m_pos[c] / 4096) % 256);
        d  = duty_cfg[c*8 +: 8];
        hi = (ph <= d);
        m_exp[c] = normal_mode && chan_en[c] && (hi != pol_inv[c]);
        if (m_tick) begin
          s = freq_cfg[c*8+6 +: 2];
          m = freq_cfg[c*8 +: 6];
          m_pos[c] = (m_pos[c] + (m + 1) * (4 ** s)) % (1 << 20);
        end
      end
      m_tick = (m_div == DIV - 1);
      m_div  = (m_div + 1) % DIV;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done)
      for (int c = 0; c < NCH; c++)
        check("R7/R9/R10 model", int'(pwm_out[c]), int'(m_exp[c]));
  end

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int hi0, hi2, rises, same23, inv01;
    logic p0;
    // ch0: S3 M63 D63; ch1 same inverted; ch2: S3 M15 D100; ch3: S2 M63 D100
    @(negedge clk);
    freq_cfg = {8'h3F | 8'h80, 8'hCF, 8'hFF, 8'hFF};
    duty_cfg = {8'd100, 8'd100, 8'd63, 8'd63};
    pol_inv  = 4'b0010;
    chan_en  = 4'b1111;
    cyc(4);
    check("R8 reset outputs low", int'(pwm_out), 0);
    normal_mode = 1'b1;
    cyc(1);
    check("R8 reset outputs low", int'(pwm_out), 0);
    rst = 1'b0;
    cyc(6);
    hi0 = 0; hi2 = 0; rises = 0; same23 = 0; inv01 = 0; p0 = pwm_out[0];
    for (int k = 0; k < 2048; k++) begin
      cyc(1);
      if (k < 512 && pwm_out[0]) hi0++;
      if (pwm_out[2]) hi2++;
      if (pwm_out[0] && !p0) rises++;
      p0 = pwm_out[0];
      if (pwm_out[2] == pwm_out[3]) same23++;
      if (pwm_out[1] == !pwm_out[0]) inv01++;
    end
    check("R2 high cycles D63", hi0, 128);
    check("R2 high cycles D100", hi2, 808);
    check("R1 periods in window", rises, 4);
    check("R1 equal increments match", same23, 2048);
    check("R4 complement", inv01, 2048);

    duty_cfg[7:0] = 8'hFF; duty_cfg[15:8] = 8'hFF;
    cyc(1);
    hi0 = 0; inv01 = 0;
    for (int k = 0; k < 600; k++) begin
      cyc(1);
      if (pwm_out[0]) hi0++;
      if (pwm_out[1]) inv01++;
    end
    check("R3 full duty high", hi0, 600);
    check("R4 inverted full duty low", inv01, 0);

    chan_en[0] = 1'b0; pol_inv[0] = 1'b1; chan_en[1] = 1'b0;
    cyc(1);
    hi0 = 0;
    for (int k = 0; k < 600; k++) begin
      cyc(1);
      if (pwm_out[0] || pwm_out[1]) hi0++;
    end
    check("R5 disabled low", hi0, 0);

    normal_mode = 1'b0;
    cyc(1);
    hi0 = 0;
    for (int k = 0; k < 600; k++) begin
      cyc(1);
      if (pwm_out != '0) hi0++;
    end
    check("R6 mode gate low", hi0, 0);

    // R7: live changes mid-period, tracked by the model every cycle
    normal_mode = 1'b1; chan_en = 4'b1111; pol_inv = 4'b0000;
    cyc(137);
    duty_cfg[23:16] = 8'd10; freq_cfg[31:24] = 8'h45;
    cyc(300);
    freq_cfg[7:0] = 8'h05; duty_cfg[7:0] = 8'd0; pol_inv[3] = 1'b1;
    cyc(500);
    check("R7 live update output", int'(pwm_out), int'(m_exp));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule